// File: doc/BRIEF.md
# Cascadable Ripple Magnitude Comparator

This block decides how two unsigned operands of a parameterised width relate to each other and reports the answer on three flags: A greater than B, A equal to B, and A less than B. The decision is formed by a chain of one-bit cells. The chain starts at the most significant bit pair and works down to the least significant one. Each cell receives a three-signal relation from the cell above it and hands a new relation to the cell below. A cell only looks at its own bit pair while the relation coming in still says "equal". Once a higher cell has decided, every lower cell passes that decision through unchanged.

The relation entering the top cell comes from three cascade inputs. For a single comparison these are driven to "equal" (greater 0, equal 1, less 0). To compare wider words, the flags of the instance that holds the more significant slice drive the cascade inputs of the instance that holds the less significant slice. The answer then appears at the last instance. The block also routes the smaller operand to a data output: A when the final less-than flag is set, and B in every other case.

The path is purely combinational. Its settling delay grows with one cell per bit.

Top module: `magcmp_cascade`

## Requirements
- R1: With cascade inputs greater=0, equal=1, less=0, the greater flag is 1 exactly when op_a > op_b as unsigned numbers.
- R2: With cascade inputs greater=0, equal=1, less=0, the equal flag is 1 exactly when op_a == op_b.
- R3: With cascade inputs greater=0, equal=1, less=0, the less flag is 1 exactly when op_a < op_b as unsigned numbers.
- R4: Whenever exactly one cascade input is 1, exactly one of the three output flags is 1, and this includes identical operands.
- R5: With cascade greater=1, equal=0, less=0, the outputs are greater=1, equal=0, less=0 whatever the operands are.
- R6: With cascade less=1, equal=0, greater=0, the outputs are less=1, equal=0, greater=0 whatever the operands are.
- R7: min_val equals op_a when the less flag output is 1, and equals op_b otherwise. With equal operands it therefore carries op_b.
- R8: Take two instances of width W. Feed the upper halves of two 2W-bit words to the first instance and its flags to the cascade inputs of a second instance that holds the lower halves. The second instance's flags then equal those of one 2W-bit instance comparing the full words.
- R9: With all three cascade inputs at 0, all three output flags are 0 for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| cas_gt | input | 1 | Incoming "greater" decision from a more significant slice |
| cas_eq | input | 1 | Incoming "still equal" status from a more significant slice |
| cas_lt | input | 1 | Incoming "less" decision from a more significant slice |
| a_gt_b | output | 1 | Final greater flag |
| a_eq_b | output | 1 | Final equal flag |
| a_lt_b | output | 1 | Final less flag |
| min_val | output | WIDTH | op_a if the less flag is set, otherwise op_b |

## Verification
Two functions act in the same evaluation. One is the relation flags, which a cascade decision can override. The other is the minimum selector, which is steered by those final flags rather than by the local operands. The bench provokes the overlap with equal operands under a neutral cascade, where the equal flag and the B route must appear together. It also drives a forced "less" cascade with op_a larger than op_b, where the selector must follow the cascade and route A. In each cycle the bench judges both outputs against a behavioural model that computes the flags from integer comparisons and the cascade inputs. It applies the same model to the two chained 4-bit slices, set against the single 8-bit instance.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    // Relation handed from one bit cell to the next less significant one.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    // Neutral relation for a stand-alone comparison.
    localparam rel_t REL_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

    // One cell: decides on its own bit pair only while still undecided.
    function automatic rel_t rel_step(rel_t up, logic a_bit, logic b_bit);
        rel_t r;
        r.gt = up.gt | (up.eq & a_bit & ~b_bit);
        r.lt = up.lt | (up.eq & ~a_bit & b_bit);
        r.eq = up.eq & ~(a_bit ^ b_bit);
        return r;
    endfunction

endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell
    import magcmp_pkg::*;
(
    input  rel_t from_up,
    input  logic bit_a,
    input  logic bit_b,
    output rel_t to_down
);

    assign to_down = rel_step(from_up, bit_a, bit_b);

    always_comb begin
        // A decision taken above is handed down untouched.
        if (!from_up.eq)
            AST_DECIDED_PASSES: assert (to_down == from_up); // R5
        // Matching bits keep an undecided relation as it is.
        if (from_up.eq && (bit_a == bit_b))
            AST_MATCH_KEEPS: assert (to_down == from_up); // R2
    end

endmodule

// File: rtl/cmp_ripple_chain.sv
module cmp_ripple_chain
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] vec_a,
    input  logic [WIDTH-1:0] vec_b,
    input  rel_t             seed,
    output rel_t             result
);

    localparam int LINKS = WIDTH + 1;

    rel_t link [LINKS];

    assign link[WIDTH] = seed;

    generate
        for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_cell
            cmp_bit_cell u_cell (
                .from_up (link[i+1]),
                .bit_a   (vec_a[i]),
                .bit_b   (vec_b[i]),
                .to_down (link[i])
            );
        end
    endgenerate

    assign result = link[0];

endmodule

// File: rtl/cmp_min_route.sv
module cmp_min_route #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             take_a,
    output logic [WIDTH-1:0] chosen
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_mux
            assign chosen[i] = take_a ? in_a[i] : in_b[i];
        end
    endgenerate

endmodule

// File: rtl/magcmp_cascade.sv
module magcmp_cascade
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             cas_gt,
    input  logic             cas_eq,
    input  logic             cas_lt,
    output logic             a_gt_b,
    output logic             a_eq_b,
    output logic             a_lt_b,
    output logic [WIDTH-1:0] min_val
);

    rel_t seed_rel;
    rel_t final_rel;

    assign seed_rel = '{gt: cas_gt, eq: cas_eq, lt: cas_lt};

    cmp_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .vec_a  (op_a),
        .vec_b  (op_b),
        .seed   (seed_rel),
        .result (final_rel)
    );

    assign a_gt_b = final_rel.gt;
    assign a_eq_b = final_rel.eq;
    assign a_lt_b = final_rel.lt;

    cmp_min_route #(.WIDTH(WIDTH)) u_min (
        .in_a   (op_a),
        .in_b   (op_b),
        .take_a (final_rel.lt),
        .chosen (min_val)
    );

    always_comb begin
        if (seed_rel == REL_SEED) begin
            AST_GT_MATCHES: assert (a_gt_b == (op_a > op_b));  // R1
            AST_EQ_MATCHES: assert (a_eq_b == (op_a == op_b)); // R2
            AST_LT_MATCHES: assert (a_lt_b == (op_a < op_b));  // R3
            AST_MIN_IS_MIN: assert ((min_val <= op_a) && (min_val <= op_b)); // R7
        end
        if ($onehot({cas_gt, cas_eq, cas_lt}))
            AST_ONE_FLAG: assert ($onehot({a_gt_b, a_eq_b, a_lt_b})); // R4
        if (cas_gt && !cas_eq && !cas_lt)
            AST_FORCED_GT: assert (a_gt_b && !a_eq_b && !a_lt_b); // R5
        if (cas_lt && !cas_eq && !cas_gt)
            AST_FORCED_LT: assert (a_lt_b && !a_eq_b && !a_gt_b); // R6
        if (!cas_gt && !cas_eq && !cas_lt)
            AST_ZERO_SEED: assert (!a_gt_b && !a_eq_b && !a_lt_b); // R9
    end

endmodule

// File: tb/tb_magcmp_cascade.sv
module tb_magcmp_cascade;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] a8, b8;
    logic [3:0] a4, b4;
    logic       cg, ce, cl;
    logic       g8, e8, l8, g4, e4, l4, gh, eh, lh, gl, el, ll;
    logic [7:0] m8;
    logic [3:0] m4, mh, ml;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    magcmp_cascade #(.WIDTH(8)) dut (
        .op_a(a8), .op_b(b8), .cas_gt(cg), .cas_eq(ce), .cas_lt(cl),
        .a_gt_b(g8), .a_eq_b(e8), .a_lt_b(l8), .min_val(m8));

    magcmp_cascade #(.WIDTH(4)) u_w4 (
        .op_a(a4), .op_b(b4), .cas_gt(cg), .cas_eq(ce), .cas_lt(cl),
        .a_gt_b(g4), .a_eq_b(e4), .a_lt_b(l4), .min_val(m4));

    magcmp_cascade #(.WIDTH(4)) u_hi (
        .op_a(a8[7:4]), .op_b(b8[7:4]), .cas_gt(cg), .cas_eq(ce), .cas_lt(cl),
        .a_gt_b(gh), .a_eq_b(eh), .a_lt_b(lh), .min_val(mh));

    magcmp_cascade #(.WIDTH(4)) u_lo (
        .op_a(a8[3:0]), .op_b(b8[3:0]), .cas_gt(gh), .cas_eq(eh), .cas_lt(lh),
        .a_gt_b(gl), .a_eq_b(el), .a_lt_b(ll), .min_val(ml));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model of the flags: {gt, eq, lt}.
    function automatic logic [2:0] model(int unsigned x, int unsigned y,
                                         logic g, logic e, logic l);
        return {g | (e && (x > y)), e && (x == y), l | (e && (x < y))};
    endfunction

    task automatic run8(logic [7:0] a, logic [7:0] b, logic g, logic e, logic l);
        logic [2:0] exp;
        @(posedge clk);
        a8 = a; b8 = b; cg = g; ce = e; cl = l;
        @(negedge clk);
        exp = model(a, b, g, e, l);
        chk("R1 R2 R3 flags w8", {29'd0, g8, e8, l8}, {29'd0, exp});
        chk("R7 min w8", {24'd0, m8}, {24'd0, exp[0] ? a : b});
        chk("R8 chained slices", {29'd0, gl, el, ll}, {29'd0, exp});
        if ($onehot({g, e, l}))
            chk("R4 single flag w8", {31'd0, $onehot({g8, e8, l8})}, 32'd1);
    endtask

    task automatic run4(logic [3:0] a, logic [3:0] b, logic g, logic e, logic l);
        logic [2:0] exp;
        @(posedge clk);
        a4 = a; b4 = b; cg = g; ce = e; cl = l;
        @(negedge clk);
        exp = model(a, b, g, e, l);
        chk("R1 R2 R3 flags w4", {29'd0, g4, e4, l4}, {29'd0, exp});
        chk("R7 min w4", {28'd0, m4}, {28'd0, exp[0] ? a : b});
        if ($onehot({g, e, l}))
            chk("R4 single flag w4", {31'd0, $onehot({g4, e4, l4})}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        a8 = '0; b8 = '0; a4 = '0; b4 = '0; cg = 1'b0; ce = 1'b1; cl = 1'b0;
        // Starting state: zero operands under a neutral cascade read as equal.
        @(negedge clk);
        chk("R2 start state equal", {29'd0, g8, e8, l8}, 32'b010);
        chk("R7 start state min", {24'd0, m8}, 32'd0);

        // Exhaustive neutral-cascade sweep at width 4 (R1 R2 R3 R4 R7).
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                run4(4'(i), 4'(j), 1'b0, 1'b1, 1'b0);

        // Directed corners at width 8.
        run8(8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0);   // R2, R7: equal picks B
        run8(8'h80, 8'h7F, 1'b0, 1'b1, 1'b0);   // R1: MSB decides
        run8(8'h00, 8'h01, 1'b0, 1'b1, 1'b0);   // R3: LSB decides
        run8(8'h9B, 8'h99, 1'b0, 1'b1, 1'b0);   // R1

        // Cascade overrides with operands pulling the other way.
        run8(8'h00, 8'hFF, 1'b1, 1'b0, 1'b0);
        chk("R5 forced greater", {29'd0, g8, e8, l8}, 32'b100);
        run8(8'hFF, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R6 forced less", {29'd0, g8, e8, l8}, 32'b001);
        chk("R7 forced less routes A", {24'd0, m8}, 32'hFF);
        run8(8'h5A, 8'h5A, 1'b0, 1'b0, 1'b1);
        chk("R6 forced less with equal operands", {29'd0, g8, e8, l8}, 32'b001);
        run8(8'h12, 8'h34, 1'b0, 1'b0, 1'b0);
        chk("R9 zero cascade", {29'd0, g8, e8, l8}, 32'b000);
        run8(8'h34, 8'h34, 1'b0, 1'b0, 1'b0);
        chk("R9 zero cascade equal operands", {29'd0, g8, e8, l8}, 32'b000);
        run4(4'h3, 4'hC, 1'b1, 1'b0, 1'b0);
        chk("R5 forced greater w4", {29'd0, g4, e4, l4}, 32'b100);

        // Random sweep at width 8 with mixed cascade seeds (R1..R9 via model).
        for (int k = 0; k < 1500; k++) begin
            logic [2:0] s;
            s = (k % 4 == 0) ? 3'($urandom_range(0, 7)) : 3'b010;
            run8(8'($urandom), 8'($urandom), s[2], s[1], s[0]);
        end

        // Equal upper halves so the lower slice decides the chain (R8).
        run8(8'hA3, 8'hA5, 1'b0, 1'b1, 1'b0);
        run8(8'hA5, 8'hA3, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule